// File: doc/BRIEF.md
# I2C Master Read-Transfer Engine

This block is the controller side of a two-wire serial bus and reads data bytes from an EEPROM-style slave. Software programs a byte count in an 8-bit length register, then issues a command. The engine generates the Start condition, sends the 7-bit slave address with the read bit, and clocks in the programmed number of bytes. Each byte goes into an external receive FIFO. SCL and SDA are driven as open-drain pull-low enables, and SCL timing comes from a programmable divider.

Three commands exist. The automatic command always addresses the slave. The sequence command continues reading without a new address phase when the bus is being held, and otherwise behaves like the automatic command. The manual command also accepts a zero length, which performs the address phase only. Every command chooses whether the transfer ends with a Stop or keeps the bus by holding SCL low. A full FIFO stalls the bus: SCL stays low and the divider freezes until space is free. Three sticky interrupt bits report completion, a rejected zero length and an address NACK.

Top module: `i2c_rd_master`

## Requirements
- R1: The length register holds the byte count in bits [7:0]; bits [31:8] read as zero whatever was written; it resets to zero.
- R2: A write to the length register while `busy` is high leaves the register unchanged.
- R3: A transfer of length N pushes exactly N bytes into the FIFO, in the order received, each assembled MSB first from SDA.
- R4: With `cmd_stop`=1 a transfer ends with a Stop and both lines released; with `cmd_stop`=0 it ends with SCL held low (`scl_oe`=1) and SDA released.
- R5: The master ACKs every byte except the final byte of a transfer ending in Stop, which it NACKs; the final byte of a held transfer is ACKed.
- R6: While the FIFO is full at the end of a received byte, SCL is held low, the divider stops, and no push occurs until `fifo_full` drops.
- R7: A command with `cmd_kind` 0 (automatic) or 1 (sequence) and length zero starts no bus activity, leaves the bus state unchanged and sets `irq_stat[1]`.
- R8: A command with `cmd_kind` 2 (manual) and length zero sends Start and address only, then holds SCL low with no push.
- R9: A slave NACK on the address aborts the command with a Stop, sets `irq_stat[2]`, pushes nothing and does not set the done bit.
- R10: A sequence command accepted while the bus is held reads on without Start or address; any other accepted command begins with a (repeated) Start and address.
- R11: `busy` is high from command acceptance until the Stop completes or the hold state is entered; the done bit `irq_stat[0]` is then set.
- R12: Commands arriving while `busy` is high are ignored.
- R13: Interrupt bits are sticky and each is cleared by a one on the same bit of `irq_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the length register |
| reg_wdata | input | 32 | Length register write data |
| reg_rdata | output | 32 | Length register read data |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_kind | input | 2 | 0 automatic, 1 sequence, 2 manual |
| cmd_stop | input | 1 | 1 end with Stop, 0 hold the bus |
| cmd_addr | input | 7 | Slave address |
| clk_div | input | 8 | Clock cycles per quarter SCL period |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| fifo_full | input | 1 | Receive FIFO has no space |
| fifo_push | output | 1 | Write `fifo_data` into the FIFO |
| fifo_data | output | 8 | Received byte |
| busy | output | 1 | Command in progress |
| irq_clr | input | 3 | Write-one-to-clear for the interrupt bits |
| irq_stat | output | 3 | {address NACK, length error, done} |

## Verification
A corrupted byte counter appears at the FIFO port as one push too many or too few, and on the wire as an ACK/NACK on the wrong byte, within one byte time (about 36 divider periods). A wrong state after a held transfer shows up on the next command: either a spurious Start when reading should continue, or a missing address phase. Both are visible as shifted byte values from the slave model. A broken stall path appears within one quarter period as an SCL rise or a push while the FIFO reports full.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [1:0] {
    CMD_AUTO = 2'd0,
    CMD_SEQ  = 2'd1,
    CMD_MAN  = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_AACK, S_DATA, S_MACK, S_STOP, S_HOLD
  } st_e;
endpackage

// File: rtl/i2c_rd_tick.sv
module i2c_rd_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt, cnt_n;
  logic          last;

  always_comb begin
    last  = ({1'b0, cnt} + 1'b1) >= {1'b0, div};
    tick  = en && last;
    cnt_n = cnt;
    if (en) cnt_n = last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/i2c_rd_len.sv
module i2c_rd_len #(
  parameter int LW = 8,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [RW-1:0] wdata,
  input  logic          lock,
  output logic [LW-1:0] len,
  output logic [RW-1:0] rdata
);
  logic upd;

  assign upd   = wr && !lock;
  assign rdata = {{(RW-LW){1'b0}}, len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   len <= '0;
    else if (upd) len <= wdata[LW-1:0];
  end

  AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock) |=> $stable(len)); // R2
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic          tick_en,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic          cmd_stop,
  input  logic [6:0]    cmd_addr,
  input  logic [LW-1:0] len,
  input  logic          fifo_full,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          fifo_push,
  output logic [7:0]    fifo_data,
  output logic          busy,
  output logic          ev_done,
  output logic          ev_len_err,
  output logic          ev_nack
);
  st_e           st, st_n;
  logic [1:0]    q, q_n;
  logic [2:0]    bitc, bitc_n;
  logic [LW-1:0] cnt, cnt_n;
  logic [7:0]    sh, sh_n;
  logic          stop_r, stop_n;
  logic          nack_r, nack_n;
  logic          idle_like, stall, last_ack;

  assign idle_like = (st == S_IDLE) || (st == S_HOLD);
  assign stall     = (st == S_MACK) && (q == 2'd0) && fifo_full;
  assign tick_en   = !idle_like && !stall;
  assign busy      = !idle_like;
  assign fifo_push = tick && (st == S_MACK) && (q == 2'd0);
  assign fifo_data = sh;
  assign last_ack  = !((cnt == LW'(1)) && stop_r);

  // line drive, decoded from slot state and quarter
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_HOLD:  scl_oe = 1'b1;
      S_START: begin scl_oe = (q == 2'd3); sda_oe = q[1]; end
      S_ADDR:  begin scl_oe = !q[1]; sda_oe = !sh[7]; end
      S_AACK,
      S_DATA:  scl_oe = !q[1];
      S_MACK:  begin scl_oe = !q[1]; sda_oe = last_ack; end
      S_STOP:  begin scl_oe = !q[1]; sda_oe = (q != 2'd3); end
      default: ;
    endcase
  end

  always_comb begin
    st_n = st; q_n = q; bitc_n = bitc; cnt_n = cnt; sh_n = sh;
    stop_n = stop_r; nack_n = nack_r;
    ev_done = 1'b0; ev_len_err = 1'b0; ev_nack = 1'b0;
    if (idle_like && cmd_valid) begin
      if ((cmd_kind != CMD_MAN) && (len == '0)) begin
        ev_len_err = 1'b1;
      end else begin
        cnt_n  = len;
        stop_n = cmd_stop;
        sh_n   = {cmd_addr, 1'b1};
        q_n    = 2'd0;
        bitc_n = 3'd0;
        nack_n = 1'b0;
        st_n   = ((cmd_kind == CMD_SEQ) && (st == S_HOLD)) ? S_DATA : S_START;
      end
    end else if (tick) begin
      q_n = q + 2'd1;
      if (q == 2'd2 && st == S_DATA) sh_n   = {sh[6:0], sda_in};
      if (q == 2'd2 && st == S_AACK) nack_n = sda_in;
      if (q == 2'd3) begin
        case (st)
          S_START: begin st_n = S_ADDR; bitc_n = 3'd0; end
          S_ADDR: begin
            sh_n = {sh[6:0], 1'b0};
            if (bitc == 3'd7) st_n = S_AACK;
            else              bitc_n = bitc + 3'd1;
          end
          S_AACK: begin
            if (nack_r)           begin st_n = S_STOP; ev_nack = 1'b1; end
            else if (cnt == '0)   begin st_n = S_HOLD; ev_done = 1'b1; end
            else                  begin st_n = S_DATA; bitc_n = 3'd0; end
          end
          S_DATA: begin
            if (bitc == 3'd7) st_n = S_MACK;
            else              bitc_n = bitc + 3'd1;
          end
          S_MACK: begin
            cnt_n = cnt - 1'b1;
            if (cnt == LW'(1)) begin
              if (stop_r) st_n = S_STOP;
              else begin st_n = S_HOLD; ev_done = 1'b1; end
            end else begin
              st_n = S_DATA; bitc_n = 3'd0;
            end
          end
          S_STOP: begin st_n = S_IDLE; ev_done = !nack_r; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= 2'd0; bitc <= 3'd0; cnt <= '0; sh <= '0;
      stop_r <= 1'b0; nack_r <= 1'b0;
    end else begin
      st <= st_n; q <= q_n; bitc <= bitc_n; cnt <= cnt_n; sh <= sh_n;
      stop_r <= stop_n; nack_r <= nack_n;
    end
  end

  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (st == S_MACK && q == 2'd0 && scl_oe)); // R6
  AST_LEN_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && st == S_IDLE && cmd_kind != CMD_MAN && len == '0) |=> (st == S_IDLE)); // R7
  AST_PUSH_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (cnt != '0)); // R3
  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> (st == S_STOP)); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && st != S_MACK) |=> $stable(cnt)); // R12
endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master #(
  parameter int LW = 8,
  parameter int RW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic          cmd_stop,
  input  logic [6:0]    cmd_addr,
  input  logic [DW-1:0] clk_div,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          fifo_full,
  output logic          fifo_push,
  output logic [7:0]    fifo_data,
  output logic          busy,
  input  logic [2:0]    irq_clr,
  output logic [2:0]    irq_stat
);
  logic [LW-1:0] len;
  logic          tick, tick_en;
  logic          ev_done, ev_len_err, ev_nack;
  logic [2:0]    irq_n;

  i2c_rd_len #(.LW(LW), .RW(RW)) u_len (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .lock(busy), .len(len), .rdata(reg_rdata)
  );

  i2c_rd_tick #(.DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .div(clk_div), .tick(tick)
  );

  i2c_rd_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tick_en(tick_en),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_stop(cmd_stop),
    .cmd_addr(cmd_addr), .len(len), .fifo_full(fifo_full), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .fifo_push(fifo_push),
    .fifo_data(fifo_data), .busy(busy), .ev_done(ev_done),
    .ev_len_err(ev_len_err), .ev_nack(ev_nack)
  );

  assign irq_n = (irq_stat & ~irq_clr) | {ev_nack, ev_len_err, ev_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_stat <= '0;
    else        irq_stat <= irq_n;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[0] && !irq_clr[0]) |=> irq_stat[0]); // R13
endmodule

// File: tb/tb_i2c_rd_master.sv
module tb_i2c_rd_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_valid, cmd_stop;
  logic [1:0]  cmd_kind;
  logic [6:0]  cmd_addr;
  logic [7:0]  clk_div;
  logic        sda_in, scl_oe, sda_oe, fifo_full, fifo_push, busy;
  logic [7:0]  fifo_data;
  logic [2:0]  irq_clr, irq_stat;

  always #5 clk = ~clk;

  i2c_rd_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_stop(cmd_stop), .cmd_addr(cmd_addr), .clk_div(clk_div),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .fifo_full(fifo_full),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .busy(busy),
    .irq_clr(irq_clr), .irq_stat(irq_stat)
  );

  // bus lines and slave model (address 0x50, bytes 0xA0 + index)
  localparam logic [6:0] SLV = 7'h50;
  logic s_low = 1'b0;
  logic scl_line, sda_line;
  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || s_low);
  assign sda_in   = sda_line;

  int         s_bit = 0, s_phase = 0, s_idx = 0;
  logic [7:0] s_sh = 8'h00;
  logic       last_mack = 1'b0;
  logic       p_scl = 1'b1, p_sda = 1'b1;

  function automatic logic [7:0] sval(input int idx);
    return 8'hA0 + idx[7:0];
  endfunction

  always @(negedge clk) begin
    logic [7:0] v;
    if (p_scl && scl_line && p_sda && !sda_line) begin
      s_phase = 1; s_bit = 0; s_low = 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      s_phase = 0; s_low = 1'b0;
    end else if (!p_scl && scl_line) begin
      if (s_phase != 0) begin
        s_bit = s_bit + 1;
        if (s_phase == 1 && s_bit <= 8) s_sh = {s_sh[6:0], sda_line};
        if (s_phase == 2 && s_bit == 9) last_mack = !sda_line;
      end
    end else if (p_scl && !scl_line) begin
      if (s_phase == 1) begin
        if (s_bit == 8) s_low = (s_sh == {SLV, 1'b1});
        else if (s_bit == 9) begin
          s_low = 1'b0;
          if (s_sh == {SLV, 1'b1}) begin
            s_phase = 2; s_idx = 0; s_bit = 0; v = sval(0); s_low = !v[7];
          end else s_phase = 0;
        end
      end else if (s_phase == 2) begin
        v = sval(s_idx);
        if (s_bit >= 1 && s_bit <= 7) s_low = !v[7 - s_bit];
        else if (s_bit == 8) s_low = 1'b0;
        else if (s_bit == 9) begin
          s_bit = 0;
          if (last_mack) begin s_idx = s_idx + 1; v = sval(s_idx); s_low = !v[7]; end
          else begin s_phase = 0; s_low = 1'b0; end
        end
      end
    end
    p_scl = scl_line;
    p_sda = !(sda_oe || s_low);
  end

  // FIFO capture
  logic [7:0] got [0:63];
  int n_got = 0;
  always @(negedge clk) if (fifo_push) begin
    if (n_got < 64) got[n_got] = fifo_data;
    n_got = n_got + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual running expected finished");
      finish_run();
    end
  end

  task automatic wr_len(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic st, input logic [6:0] a);
    @(negedge clk); irq_clr = 3'b111;
    @(negedge clk); irq_clr = 3'b000;
    n_got = 0;
    cmd_valid = 1'b1; cmd_kind = k; cmd_stop = st; cmd_addr = a;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 20000) begin @(negedge clk); g++; end
    repeat (4) @(negedge clk);
  endtask

  // vector: kind[19:18] stop[17] len[16:9] first[8:1] hold[0]
  localparam int NV = 8;
  localparam logic [19:0] VEC [0:NV-1] = '{
    {2'd0, 1'b1, 8'd3, 8'hA0, 1'b0},
    {2'd0, 1'b0, 8'd2, 8'hA0, 1'b1},
    {2'd1, 1'b1, 8'd2, 8'hA2, 1'b0},
    {2'd2, 1'b0, 8'd0, 8'hA0, 1'b1},
    {2'd1, 1'b1, 8'd1, 8'hA0, 1'b0},
    {2'd2, 1'b1, 8'd4, 8'hA0, 1'b0},
    {2'd1, 1'b0, 8'd1, 8'hA0, 1'b1},
    {2'd0, 1'b1, 8'd2, 8'hA0, 1'b0}
  };

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; cmd_valid = 1'b0;
    cmd_kind = 2'd0; cmd_stop = 1'b0; cmd_addr = SLV; clk_div = 8'd4;
    fifo_full = 1'b0; irq_clr = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1", "reset length", reg_rdata, 32'h0);
    chk("R11", "reset busy", {31'b0, busy}, 32'h0);
    chk("R4", "reset lines", {30'b0, scl_oe, sda_oe}, 32'h0);
    chk("R13", "reset irq", {29'b0, irq_stat}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;  logic st, hold; logic [7:0] ln, fst;
      {k, st, ln, fst, hold} = VEC[i];
      wr_len({24'h0, ln});
      issue(k, st, SLV);
      wait_idle();
      chk("R3", $sformatf("vec%0d byte count", i), n_got, {24'h0, ln});
      for (int j = 0; j < n_got && j < 64; j++)
        chk(k == 2'd1 ? "R10" : "R3", $sformatf("vec%0d byte%0d", i, j), {24'h0, got[j]}, {24'h0, fst + j[7:0]});
      if (hold) chk(ln == 0 ? "R8" : "R4", $sformatf("vec%0d held", i), {30'b0, scl_oe, sda_oe}, 32'h2);
      else      chk("R4", $sformatf("vec%0d released", i), {30'b0, scl_oe, sda_oe}, 32'h0);
      chk("R11", $sformatf("vec%0d busy/done", i), {30'b0, busy, irq_stat[0]}, 32'h1);
      if (ln != 0) chk("R5", $sformatf("vec%0d final ack", i), {31'b0, last_mack}, {31'b0, !st});
    end

    // R1 reserved bits
    wr_len(32'hFFFF_FF07);
    @(negedge clk);
    chk("R1", "reserved bits zero", reg_rdata, 32'h0000_0007);

    // R2 and R12: write and command while busy
    wr_len(32'h3);
    issue(2'd0, 1'b1, SLV);
    repeat (20) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 32'h55; cmd_valid = 1'b1; cmd_kind = 2'd2; cmd_stop = 1'b0;
    @(negedge clk); reg_wr = 1'b0; cmd_valid = 1'b0;
    wait_idle();
    chk("R2", "length locked", reg_rdata, 32'h3);
    chk("R12", "second command ignored", n_got, 32'd3);
    chk("R12", "ended released", {30'b0, scl_oe, sda_oe}, 32'h0);

    // R7 zero length automatic from idle
    wr_len(32'h0);
    issue(2'd0, 1'b1, SLV);
    begin
      logic act = 1'b0;
      for (int c = 0; c < 40; c++) begin @(negedge clk); act |= scl_oe | sda_oe | busy; end
      chk("R7", "auto zero no activity", {31'b0, act}, 32'h0);
    end
    chk("R7", "auto zero error bit", {29'b0, irq_stat}, 32'h2);

    // R7 zero length sequence from hold
    wr_len(32'h0);
    issue(2'd2, 1'b0, SLV);
    wait_idle();
    issue(2'd1, 1'b1, SLV);
    repeat (40) @(negedge clk);
    chk("R7", "seq zero keeps hold", {29'b0, busy, scl_oe, sda_oe}, 32'h2);
    chk("R7", "seq zero error bit", {29'b0, irq_stat}, 32'h2);
    wr_len(32'h1);
    issue(2'd0, 1'b1, SLV);
    wait_idle();
    chk("R10", "repeated start from hold", {24'h0, got[0]}, 32'hA0);

    // R13 clear
    @(negedge clk); irq_clr = 3'b001;
    @(negedge clk); irq_clr = 3'b000;
    chk("R13", "done cleared", {29'b0, irq_stat}, 32'h0);

    // R9 address NACK
    wr_len(32'h2);
    issue(2'd0, 1'b1, 7'h22);
    wait_idle();
    chk("R9", "nack irq only", {29'b0, irq_stat}, 32'h4);
    chk("R9", "nack no push", n_got, 32'd0);
    chk("R9", "nack released", {30'b0, scl_oe, sda_oe}, 32'h0);

    // R6 FIFO full stall
    fifo_full = 1'b1;
    wr_len(32'h2);
    issue(2'd0, 1'b1, SLV);
    repeat (600) @(negedge clk);
    begin
      logic rose = 1'b0;
      for (int c = 0; c < 60; c++) begin @(negedge clk); rose |= !scl_oe; end
      chk("R6", "scl low while full", {31'b0, rose}, 32'h0);
    end
    chk("R6", "no push while full", n_got, 32'd0);
    chk("R6", "busy while stalled", {31'b0, busy}, 32'h1);
    fifo_full = 1'b0;
    wait_idle();
    chk("R6", "bytes after stall", n_got, 32'd2);
    chk("R6", "first byte after stall", {24'h0, got[0]}, 32'hA0);
    chk("R5", "stop nack after stall", {31'b0, last_mack}, 32'h0);

    done_flag = 1;
    finish_run();
  end
endmodule